// File: doc/BRIEF.md
# Width-Adapting Register Bus Bridge

This bridge sits between a processor-side register bus and a bank of peripheral registers. The processor issues byte, 16-bit or 32-bit accesses at any legal offset. The registers behind the bridge each have a fixed native width of 1, 2 or 4 bytes. The bridge looks up that width for every 4-byte address group and turns each processor access into one or more native accesses of exactly that width.

When the processor access is wider than the native registers, the bridge splits it into a run of native accesses at ascending offsets. The most significant part goes first, so the ordering is big-endian. When the access is narrower than the native register, a read fetches the whole containing register and extracts the addressed lane. A write does a read-modify-write that changes only the addressed lane. Accesses that fall outside the decoded window, hit an unused group, use an illegal size code or are misaligned end with an error response and do not touch the native port.

The native port is a simple single-cycle port. Each native access occupies one cycle, and read data is returned in that same cycle. Native accesses are issued back to back, one per cycle. A one-cycle response pulse follows the last native access.

Top module: `regbus_width_bridge`

## Requirements
- R1: Only the low 10 bits of `reqAddr` form the offset. An access whose address differs only in bits above bit 9 behaves identically.
- R2: The native width of a 4-byte group is fixed by offset. Offsets 0x000–0x03F and 0x100–0x203 are 1 byte wide. Offsets 0x040–0x07F are 2 bytes wide. Offsets 0x080–0x0BF are 4 bytes wide. Offsets 0x0C0–0x0FF and everything above 0x203 are unused. Every native access carries the width of its group in `natWidth` (1, 2 or 4) and is aligned to that width.
- R3: An access gets `respErr` = 1, performs no native access and changes no register in any of these cases: its last byte lies above offset 0x200; its group is unused; `reqSize` = 3; or it is misaligned (a 16-bit access at an odd offset, or a 32-bit access at an offset that is not a multiple of 4).
- R4: When the access size is at least the native width W, the bridge issues size/W native accesses at offset, offset+W, and so on. The first of these carries the most significant part of the data.
- R5: A byte read of a 2- or 4-byte register performs one native read of the containing register. It returns byte (offset mod W) counted from the most significant end.
- R6: A 16-bit read of a 4-byte register performs one native read. It returns bits 31:16 when offset mod 4 is 0, and bits 15:0 otherwise.
- R7: A byte or 16-bit write narrower than W performs exactly two native accesses: a read of the containing register, then a write of it in which only the addressed lane, placed as in R5 and R6, is replaced.
- R8: `reqSize` 0, 1 and 2 select byte, 16-bit and 32-bit accesses. Write and read data are right-justified in 32 bits. `respRdata` is 0 for writes and for error responses.
- R9: `reqReady` is high only when the bridge is idle. After the last native access, `respValid` is high for exactly one cycle. The bridge is then ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor access request |
| reqReady | output | 1 | Bridge idle, request accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| reqAddr | input | ADDR_W | Access offset; only bits 9:0 used |
| reqWdata | input | 32 | Right-justified write data |
| respValid | output | 1 | One-cycle completion pulse |
| respErr | output | 1 | Error flag, valid with respValid |
| respRdata | output | 32 | Right-justified read data, valid with respValid |
| natValid | output | 1 | Native access this cycle |
| natWrite | output | 1 | Native access is a write |
| natAddr | output | 10 | Native access offset, aligned to natWidth |
| natWidth | output | 3 | Native access width in bytes (1, 2, 4) |
| natWdata | output | 32 | Right-justified native write data |
| natRdata | input | 32 | Right-justified native read data, same cycle |

## Verification
The checker watches every cycle for these properties: native accesses are aligned to a legal width and stay inside the window, no request is taken while native accesses are in flight, the response is a single-cycle pulse, error responses are never preceded by a native access, and good responses always are. The byte ordering of split accesses, lane selection inside wider registers, and the preservation of untouched lanes during read-modify-write depend on data values across several cycles. Only the bench scenarios show these. They compare the whole register image against a plain big-endian byte model and count the native reads and writes of each access.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int OFF_W  = 10;
  localparam int GRP_W  = OFF_W - 2;
  localparam int DATA_W = 32;
  localparam int SH_W   = $clog2(DATA_W) + 1;
  localparam logic [OFF_W-1:0] LAST_OFF = 10'h200;

  // group boundaries (group = offset >> 2)
  localparam logic [GRP_W-1:0] GRP_HALF_START = 8'h10;
  localparam logic [GRP_W-1:0] GRP_LONG_START = 8'h20;
  localparam logic [GRP_W-1:0] GRP_GAP_START  = 8'h30;
  localparam logic [GRP_W-1:0] GRP_TAIL_START = 8'h40;
  localparam logic [GRP_W-1:0] GRP_TAIL_LAST  = 8'h80;

  typedef struct packed {
    logic load;
    logic issue;
    logic respond;
  } seqStrobe_t;

  function automatic logic [2:0] groupWidth(input logic [GRP_W-1:0] grp);
    if (grp < GRP_HALF_START)       return 3'd1;
    else if (grp < GRP_LONG_START)  return 3'd2;
    else if (grp < GRP_GAP_START)   return 3'd4;
    else if (grp < GRP_TAIL_START)  return 3'd0;
    else if (grp <= GRP_TAIL_LAST)  return 3'd1;
    else                            return 3'd0;
  endfunction

  function automatic logic [1:0] widthLog(input logic [2:0] w);
    if (w == 3'd4)      return 2'd2;
    else if (w == 3'd2) return 2'd1;
    else                return 2'd0;
  endfunction

  function automatic logic [DATA_W-1:0] byteMask(input logic [2:0] nBytes);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W/8; b++)
      if (b < int'(nBytes)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [1:0]        opIdx,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] natRdata,
  output logic              planErr,
  output logic [2:0]        planOps,
  output logic              natWrite,
  output logic [OFF_W-1:0]  natAddr,
  output logic [2:0]        natWidth,
  output logic [DATA_W-1:0] natWdata,
  output logic [DATA_W-1:0] respRdata
);
  // ---- plan from the live request ----
  logic [OFF_W-1:0] inOff;
  logic [2:0]       inBytes, inWidth;
  logic             misAlign, inCont;
  logic [OFF_W:0]   lastByte;
  logic             unusedAddrBits;

  assign unusedAddrBits = ^reqAddr[ADDR_W-1:OFF_W];

  always_comb begin
    inOff   = reqAddr[OFF_W-1:0];
    inWidth = groupWidth(inOff[OFF_W-1:2]);
    case (reqSize)
      2'd0:    inBytes = 3'd1;
      2'd1:    inBytes = 3'd2;
      default: inBytes = 3'd4;
    endcase
    misAlign = (reqSize == 2'd1 && inOff[0]) || (reqSize == 2'd2 && inOff[1:0] != 2'd0);
    lastByte = {1'b0, inOff} + (OFF_W+1)'(inBytes) - (OFF_W+1)'(1);
    planErr  = (reqSize == 2'd3) || misAlign || (lastByte > {1'b0, LAST_OFF}) || (inWidth == 3'd0);
    inCont   = inBytes < inWidth;
    if (inCont) planOps = reqWrite ? 3'd2 : 3'd1;
    else        planOps = inBytes >> widthLog(inWidth);
  end

  // ---- latched access ----
  logic [OFF_W-1:0]  offReg;
  logic [2:0]        bytesReg, widthReg, opsReg;
  logic              wrReg, contMode;
  logic [DATA_W-1:0] wdataReg, contReg, rdAcc;

  // ---- lane and split arithmetic ----
  logic [2:0]        wm1, laneIdx, laneGap, splitGap;
  logic [SH_W-1:0]   fieldShift, splitShift, widthShift;
  logic [DATA_W-1:0] fieldMask, mergedCont;

  always_comb begin
    wm1        = widthReg - 3'd1;
    laneIdx    = {1'b0, offReg[1:0]} & wm1;
    laneGap    = widthReg - bytesReg - laneIdx;
    fieldShift = {laneGap, 3'b000};
    splitGap   = opsReg - 3'd1 - {1'b0, opIdx};
    splitShift = {splitGap, 3'b000} << widthLog(widthReg);
    widthShift = {widthReg, 3'b000};
    fieldMask  = byteMask(bytesReg) << fieldShift;
    mergedCont = (contReg & ~fieldMask) | ((wdataReg & byteMask(bytesReg)) << fieldShift);

    natWidth = widthReg;
    if (contMode) begin
      natAddr  = offReg & ~OFF_W'(wm1);
      natWrite = wrReg && (opIdx == 2'd1);
      natWdata = mergedCont;
    end else begin
      natAddr  = offReg + (OFF_W'(opIdx) << widthLog(widthReg));
      natWrite = wrReg;
      natWdata = (wdataReg >> splitShift) & byteMask(widthReg);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg   <= '0;
      bytesReg <= 3'd1;
      widthReg <= 3'd1;
      opsReg   <= 3'd1;
      wrReg    <= 1'b0;
      contMode <= 1'b0;
      wdataReg <= '0;
      contReg  <= '0;
      rdAcc    <= '0;
    end else if (strobe.load) begin
      offReg   <= inOff;
      bytesReg <= inBytes;
      widthReg <= inWidth;
      opsReg   <= planOps;
      wrReg    <= reqWrite;
      contMode <= inCont;
      wdataReg <= reqWdata;
      contReg  <= '0;
      rdAcc    <= '0;
    end else if (strobe.issue && !natWrite) begin
      if (contMode) begin
        contReg <= natRdata & byteMask(widthReg);
        if (!wrReg) rdAcc <= (natRdata >> fieldShift) & byteMask(bytesReg);
      end else begin
        rdAcc <= (rdAcc << widthShift) | (natRdata & byteMask(widthReg));
      end
    end
  end

  assign respRdata = rdAcc;
endmodule

// File: rtl/bridge_control.sv
module bridge_control
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       planErr,
  input  logic [2:0] planOps,
  output seqStrobe_t strobe,
  output logic [1:0] opIdx,
  output logic       reqReady,
  output logic       respValid,
  output logic       respErr
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESP} seqState_t;

  seqState_t  state;
  logic [2:0] totalReg;
  logic [1:0] idxReg;
  logic       errReg;

  always_comb begin
    strobe.load    = (state == S_IDLE) && reqValid;
    strobe.issue   = (state == S_ISSUE);
    strobe.respond = (state == S_RESP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      totalReg <= 3'd1;
      idxReg   <= 2'd0;
      errReg   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          errReg   <= planErr;
          totalReg <= planOps;
          idxReg   <= 2'd0;
          state    <= planErr ? S_RESP : S_ISSUE;
        end
        S_ISSUE: begin
          if ({1'b0, idxReg} == totalReg - 3'd1) state <= S_RESP;
          else idxReg <= idxReg + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign opIdx     = idxReg;
  assign reqReady  = (state == S_IDLE);
  assign respValid = strobe.respond;
  assign respErr   = strobe.respond && errReg;
endmodule

// File: rtl/regbus_width_bridge.sv
module regbus_width_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              respValid,
  output logic              respErr,
  output logic [31:0]       respRdata,
  output logic              natValid,
  output logic              natWrite,
  output logic [9:0]        natAddr,
  output logic [2:0]        natWidth,
  output logic [31:0]       natWdata,
  input  logic [31:0]       natRdata
);
  seqStrobe_t strobe;
  logic [1:0] opIdx;
  logic       planErr;
  logic [2:0] planOps;

  bridge_control ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .planErr(planErr), .planOps(planOps),
    .strobe(strobe), .opIdx(opIdx),
    .reqReady(reqReady), .respValid(respValid), .respErr(respErr)
  );

  bridge_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIdx(opIdx),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .natRdata(natRdata),
    .planErr(planErr), .planOps(planOps),
    .natWrite(natWrite), .natAddr(natAddr), .natWidth(natWidth),
    .natWdata(natWdata), .respRdata(respRdata)
  );

  assign natValid = strobe.issue;
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       respValid,
  input logic       respErr,
  input logic       natValid,
  input logic [9:0] natAddr,
  input logic [2:0] natWidth
);
  a_r2_native_aligned: assert property (@(posedge clk) disable iff (!rstN)
    natValid |-> ((natWidth == 3'd1 || natWidth == 3'd2 || natWidth == 3'd4) &&
                  ((natAddr & 10'(natWidth - 3'd1)) == 10'd0)));

  a_r3_native_in_window: assert property (@(posedge clk) disable iff (!rstN)
    natValid |-> (natAddr <= 10'h200));

  a_r3_error_without_native: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respErr) |-> !$past(natValid));

  a_r9_good_resp_after_native: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respErr) |-> $past(natValid));

  a_r9_resp_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));

  a_r9_busy_while_native: assert property (@(posedge clk) disable iff (!rstN)
    natValid |-> !reqReady);
endmodule

bind regbus_width_bridge bridge_checker chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .respValid(respValid),
  .respErr(respErr), .natValid(natValid), .natAddr(natAddr), .natWidth(natWidth)
);

// File: tb/regbus_width_bridge_tb.sv
module regbus_width_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, respValid, respErr;
  logic [31:0] respRdata;
  logic        natValid, natWrite;
  logic [9:0]  natAddr;
  logic [2:0]  natWidth;
  logic [31:0] natWdata, natRdata;

  always #2 clk = ~clk;

  regbus_width_bridge dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .respValid(respValid), .respErr(respErr), .respRdata(respRdata),
    .natValid(natValid), .natWrite(natWrite), .natAddr(natAddr),
    .natWidth(natWidth), .natWdata(natWdata), .natRdata(natRdata)
  );

  // register image behind the native port, plus the bench's own expectation
  logic [7:0] mem    [0:1023];
  logic [7:0] refMem [0:1023];

  always_comb begin
    natRdata = '0;
    for (int b = 0; b < 4; b++)
      if (b < int'(natWidth)) natRdata = (natRdata << 8) | 32'(mem[(int'(natAddr) + b) & 1023]);
  end

  always @(posedge clk)
    if (natValid && natWrite)
      for (int b = 0; b < 4; b++)
        if (b < int'(natWidth))
          mem[(int'(natAddr) + b) & 1023] <= 8'(natWdata >> ((int'(natWidth) - 1 - b) * 8));

  int checks = 0, fails = 0;
  int opsSeen, wrSeen, widthBad, expW;
  bit testDone = 0;

  always @(negedge clk)
    if (natValid) begin
      opsSeen++;
      if (natWrite) wrSeen++;
      if (int'(natWidth) != expW) widthBad++;
    end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // width per R2, written from the requirement's offset ranges
  function automatic int benchWidth(input int off);
    if (off < 'h040) return 1;
    if (off < 'h080) return 2;
    if (off < 'h0C0) return 4;
    if (off < 'h100) return 0;
    if (off < 'h204) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] refRead(input int off, input int nBytes);
    logic [31:0] v = '0;
    for (int b = 0; b < nBytes; b++) v = (v << 8) | 32'(refMem[off + b]);
    return v;
  endfunction

  function automatic int memMismatch();
    int n = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refMem[i]) n++;
    return n;
  endfunction

  bit pulseOk;

  task automatic doAccess(input bit wr, input logic [1:0] sz, input logic [15:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd, output bit err);
    @(negedge clk);
    opsSeen = 0; wrSeen = 0; widthBad = 0;
    expW = benchWidth(int'(addr[9:0]));
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid) @(negedge clk);
    rd = respRdata; err = respErr;
    @(negedge clk);
    pulseOk = !respValid && reqReady;
  endtask

  task automatic runRead(input string req, input logic [1:0] sz, input logic [15:0] addr, input int expOps);
    logic [31:0] rd; bit err;
    int nb = 1 << sz;
    logic [31:0] exp = refRead(int'(addr[9:0]), nb);
    doAccess(1'b0, sz, addr, '0, rd, err);
    check(!err, req, 32'(err), 0);
    check(rd === exp, req, rd, exp);
    check(opsSeen == expOps, {req, " op count"}, opsSeen, expOps);
    check(wrSeen == 0 && widthBad == 0, {req, " R2 native width/no write"}, widthBad + wrSeen, 0);
    check(pulseOk, "R9 response pulse", 32'(pulseOk), 1);
  endtask

  task automatic runWrite(input string req, input logic [1:0] sz, input logic [15:0] addr,
                          input logic [31:0] wd, input int expOps, input int expWr);
    logic [31:0] rd; bit err;
    int nb = 1 << sz;
    int off = int'(addr[9:0]);
    for (int b = 0; b < nb; b++) refMem[off + b] = 8'(wd >> ((nb - 1 - b) * 8));
    doAccess(1'b1, sz, addr, wd, rd, err);
    check(!err, req, 32'(err), 0);
    check(rd == 32'd0, "R8 write returns zero", rd, 0);
    check(opsSeen == expOps && wrSeen == expWr, {req, " ops/writes"}, opsSeen * 16 + wrSeen, expOps * 16 + expWr);
    check(widthBad == 0, "R2 native width", widthBad, 0);
    check(memMismatch() == 0, {req, " register image"}, memMismatch(), 0);
  endtask

  task automatic runError(input string req, input bit wr, input logic [1:0] sz, input logic [15:0] addr);
    logic [31:0] rd; bit err;
    doAccess(wr, sz, addr, 32'hA5A5_5A5A, rd, err);
    check(err, req, 32'(err), 1);
    check(opsSeen == 0, {req, " no native access"}, opsSeen, 0);
    check(rd == 32'd0, "R8 error returns zero", rd, 0);
    check(memMismatch() == 0, {req, " nothing changed"}, memMismatch(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(reqReady && !respValid && !natValid, "R9 reset state",
          {29'd0, reqReady, respValid, natValid}, 32'd4);
  endtask

  task automatic t_split_reads();
    runRead("R4 byte in 1-byte group", 2'd0, 16'h0010, 1);
    runRead("R4 16-bit over 1-byte group", 2'd1, 16'h0012, 2);
    runRead("R4 32-bit over 1-byte group", 2'd2, 16'h0020, 4);
    runRead("R4 16-bit native", 2'd1, 16'h0042, 1);
    runRead("R4 32-bit over 2-byte group", 2'd2, 16'h0044, 2);
    runRead("R4 32-bit native", 2'd2, 16'h0084, 1);
  endtask

  task automatic t_narrow_reads();
    runRead("R5 byte odd lane of 2-byte", 2'd0, 16'h0043, 1);
    runRead("R5 byte even lane of 2-byte", 2'd0, 16'h0046, 1);
    runRead("R5 byte lane 1 of 4-byte", 2'd0, 16'h0085, 1);
    runRead("R5 byte lane 3 of 4-byte", 2'd0, 16'h008B, 1);
    runRead("R6 upper half of 4-byte", 2'd1, 16'h0080, 1);
    runRead("R6 lower half of 4-byte", 2'd1, 16'h0082, 1);
  endtask

  task automatic t_writes();
    runWrite("R4 32-bit write over 2-byte", 2'd2, 16'h0048, 32'hDEAD_BEEF, 2, 2);
    runRead("R4 readback 2-byte split", 2'd2, 16'h0048, 2);
    runWrite("R4 32-bit write over 1-byte", 2'd2, 16'h0030, 32'h1234_5678, 4, 4);
    runWrite("R4 32-bit write native", 2'd2, 16'h0090, 32'hCAFE_F00D, 1, 1);
    runWrite("R7 byte write lane 3 of 4-byte", 2'd0, 16'h0087, 32'h0000_00C3, 2, 1);
    runWrite("R7 byte write lane 0 of 4-byte", 2'd0, 16'h0094, 32'h0000_005E, 2, 1);
    runWrite("R7 16-bit write lower half", 2'd1, 16'h008A, 32'h0000_9ABC, 2, 1);
    runWrite("R7 16-bit write upper half", 2'd1, 16'h0098, 32'h0000_4321, 2, 1);
    runWrite("R7 byte write odd lane of 2-byte", 2'd0, 16'h0041, 32'h0000_0077, 2, 1);
    runRead("R7 readback merged 4-byte", 2'd2, 16'h0084, 1);
  endtask

  task automatic t_errors();
    runError("R3 unused group", 1'b0, 2'd1, 16'h00C4);
    runError("R3 unused group write", 1'b1, 2'd0, 16'h00FF);
    runError("R3 byte above window", 1'b0, 2'd0, 16'h0201);
    runError("R3 16-bit crossing window end", 1'b1, 2'd1, 16'h0200);
    runError("R3 size code 3", 1'b0, 2'd3, 16'h0010);
    runError("R3 misaligned 16-bit", 1'b1, 2'd1, 16'h0021);
    runError("R3 misaligned 32-bit", 1'b0, 2'd2, 16'h0042);
    runRead("R3 last legal byte", 2'd0, 16'h0200, 1);
  endtask

  task automatic t_high_bits();
    runRead("R1 high address bits ignored", 2'd0, 16'hFC10, 1);
    runWrite("R1 write with high bits", 2'd1, 16'h8050, 32'h0000_B00C, 1, 1);
    runRead("R1 readback plain offset", 2'd1, 16'h0050, 1);
    runRead("R8 32-bit right-justified", 2'd2, 16'h0050, 2);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 8'((i * 7 + 3) ^ (i >> 3));
      refMem[i] = 8'((i * 7 + 3) ^ (i >> 3));
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_split_reads();
    t_narrow_reads();
    t_writes();
    t_errors();
    t_high_bits();
    testDone = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!testDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule